// File: doc/BRIEF.md
# I2C START/STOP condition generator

This block drives the open-drain SCL and SDA lines of an I2C master, through active-high drive enables, to produce a START or a STOP condition when software writes a particular bit combination into the status register. A START is requested by writing the master, transmit and busy bits as 1 together while the bus is idle. A STOP is requested by writing master and transmit as 1 and busy as 0 while the interface is enabled. Each condition is timed in system clock cycles. The cycle count comes from a small table selected by the clock mode (standard or high-speed), the long/short selection bit and the kind of condition.

After a START, the block keeps both lines driven low, which holds the bus with the clock low. It also pulses a bit-counter clear, so a byte shifter can begin clocking the first byte. A later STOP request releases SCL, holds SDA low for the STOP setup time, and then releases SDA. Every finished sequence is marked by a one-cycle done pulse.

Top module: `i2c_cond_gen`

## Requirements
- R1: While reset is asserted and after it is released, both drive enables are 0 (lines released), and done and bit-counter-clear are 0.
- R2: A START is accepted only on a status write with master=1, transmit=1 and busy=1 while `bus_busy` is 0 and the block is idle (no sequence running and the bus not held after a START).
- R3: A STOP is accepted only on a status write with master=1, transmit=1 and busy=0 while `if_en` is 1 and no sequence is running. It is accepted both from idle and while the bus is held after a START.
- R4: A START sequence leaves both lines released for T cycles (setup). It then drives SDA alone for T cycles (hold, equal to setup). After that it drives both SCL and SDA until a STOP.
- R5: The START length T is 20 (`fast_mode`=0, `long_sel`=0), 52 (0,1), 10 (1,0) or 26 (1,1) cycles.
- R6: The STOP length T is 22 (`fast_mode`=0, `long_sel`=0), 54 (0,1), 12 (1,0) or 28 (1,1) cycles.
- R7: A STOP sequence releases SCL and drives SDA for T cycles, then releases SDA. SDA is released only while SCL is released.
- R8: `cond_done` is a one-cycle pulse in the first cycle after each sequence ends. `bit_clr` pulses together with it only at the end of a START.
- R9: Status writes during a running sequence are ignored. Changes of `fast_mode` and `long_sel` after a request is accepted do not alter its timing.
- R10: A START request is ignored while `bus_busy` is 1 or the bus is held after a START. A STOP request is ignored while `if_en` is 0. A write with master=0 or transmit=0 does nothing.
- R11: SCL is never driven while SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_wr | input | 1 | One-cycle status register write strobe |
| wr_master | input | 1 | Master bit of the write |
| wr_xmit | input | 1 | Transmit bit of the write |
| wr_busy | input | 1 | Busy bit of the write |
| if_en | input | 1 | Interface enable |
| fast_mode | input | 1 | 0 = standard clock mode, 1 = high-speed mode |
| long_sel | input | 1 | 0 = short timing, 1 = long timing |
| bus_busy | input | 1 | Bus-busy flag from the condition detector |
| scl_drv | output | 1 | SCL pull-low enable (1 = drive low) |
| sda_drv | output | 1 | SDA pull-low enable (1 = drive low) |
| cond_done | output | 1 | Pulse: a condition sequence finished |
| bit_clr | output | 1 | Pulse: clear the byte bit counter after a START |

## Verification
The assertions assume `stat_wr` is a single-cycle strobe and that `bus_busy` reflects the bus state only where the START gate samples it. They make no assumption about `fast_mode` or `long_sel` being stable, because the design latches the period on acceptance. The stimulus drives every write for exactly one cycle and keeps `bus_busy` at 0 except in the directed cases that test the START gate. It also scrambles `fast_mode` and `long_sel` on every cycle of randomly chosen sequences, and injects conflicting writes in the middle of a sequence to test that they are ignored.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [2:0] {
        CS_IDLE     = 3'd0,
        CS_ST_SETUP = 3'd1,
        CS_ST_HOLD  = 3'd2,
        CS_OWNED    = 3'd3,
        CS_SP_SETUP = 3'd4
    } cond_state_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/cond_req_decode.sv
module cond_req_decode (
    input  logic stat_wr,
    input  logic wr_master,
    input  logic wr_xmit,
    input  logic wr_busy,
    input  logic if_en,
    input  logic bus_busy,
    output logic start_req,
    output logic stop_req
);

    logic ctl_pair;

    always_comb begin
        ctl_pair  = stat_wr & wr_master & wr_xmit;
        start_req = ctl_pair &  wr_busy & ~bus_busy;
        stop_req  = ctl_pair & ~wr_busy &  if_en;
    end

endmodule

// File: rtl/cond_time_sel.sv
module cond_time_sel #(
    parameter int STD_START_SHORT  = 20,
    parameter int STD_START_LONG   = 52,
    parameter int FAST_START_SHORT = 10,
    parameter int FAST_START_LONG  = 26,
    parameter int STD_STOP_SHORT   = 22,
    parameter int STD_STOP_LONG    = 54,
    parameter int FAST_STOP_SHORT  = 12,
    parameter int FAST_STOP_LONG   = 28,
    parameter int CNT_W            = 6
) (
    input  logic             is_stop,
    input  logic             fast_mode,
    input  logic             long_sel,
    output logic [CNT_W-1:0] period
);

    localparam int N_ENT = 8;
    localparam int TBL [N_ENT] = '{
        STD_START_SHORT, STD_START_LONG, FAST_START_SHORT, FAST_START_LONG,
        STD_STOP_SHORT,  STD_STOP_LONG,  FAST_STOP_SHORT,  FAST_STOP_LONG
    };

    logic [2:0]       idx;
    logic [CNT_W-1:0] ent [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign ent[g] = CNT_W'(TBL[g]);
    end

    always_comb begin
        idx    = {is_stop, fast_mode, long_sel};
        period = ent[idx];
    end

endmodule

// File: rtl/cond_sequencer.sv
module cond_sequencer
    import i2c_cond_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic [CNT_W-1:0] len_in,
    output logic             scl_drv,
    output logic             sda_drv,
    output logic             done,
    output logic             bit_clr
);

    typedef struct packed {
        cond_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic             done;
        logic             clr;
    } seq_t;

    seq_t seq_q, seq_d;
    logic cnt_zero;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.clr  = 1'b0;
        cnt_zero   = (seq_q.cnt == '0);
        unique case (seq_q.st)
            CS_IDLE: begin
                if (start_req) begin
                    seq_d.st  = CS_ST_SETUP;
                    seq_d.cnt = len_in - 1'b1;
                    seq_d.per = len_in;
                end else if (stop_req) begin
                    seq_d.st  = CS_SP_SETUP;
                    seq_d.cnt = len_in - 1'b1;
                    seq_d.per = len_in;
                end
            end
            CS_OWNED: begin
                if (stop_req) begin
                    seq_d.st  = CS_SP_SETUP;
                    seq_d.cnt = len_in - 1'b1;
                    seq_d.per = len_in;
                end
            end
            CS_ST_SETUP: begin
                if (cnt_zero) begin
                    seq_d.st  = CS_ST_HOLD;
                    seq_d.cnt = seq_q.per - 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            CS_ST_HOLD: begin
                if (cnt_zero) begin
                    seq_d.st   = CS_OWNED;
                    seq_d.done = 1'b1;
                    seq_d.clr  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            CS_SP_SETUP: begin
                if (cnt_zero) begin
                    seq_d.st   = CS_IDLE;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: CS_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        scl_drv = (seq_q.st == CS_OWNED);
        sda_drv = (seq_q.st == CS_ST_HOLD) || (seq_q.st == CS_OWNED)
               || (seq_q.st == CS_SP_SETUP);
        done    = seq_q.done;
        bit_clr = seq_q.clr;
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == CS_IDLE && start_req) |=> (seq_q.st == CS_ST_SETUP));

    // R9
    count_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == CS_ST_SETUP || seq_q.st == CS_ST_HOLD || seq_q.st == CS_SP_SETUP)
         && seq_q.cnt != '0)
        |=> (seq_q.st == $past(seq_q.st) && seq_q.cnt == $past(seq_q.cnt) - 1'b1));

    // R10
    owned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == CS_OWNED && !stop_req) |=> (seq_q.st == CS_OWNED));

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int STD_START_SHORT  = 20,
    parameter int STD_START_LONG   = 52,
    parameter int FAST_START_SHORT = 10,
    parameter int FAST_START_LONG  = 26,
    parameter int STD_STOP_SHORT   = 22,
    parameter int STD_STOP_LONG    = 54,
    parameter int FAST_STOP_SHORT  = 12,
    parameter int FAST_STOP_LONG   = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_wr,
    input  logic wr_master,
    input  logic wr_xmit,
    input  logic wr_busy,
    input  logic if_en,
    input  logic fast_mode,
    input  logic long_sel,
    input  logic bus_busy,
    output logic scl_drv,
    output logic sda_drv,
    output logic cond_done,
    output logic bit_clr
);

    localparam int MAX_START = max_of4(STD_START_SHORT, STD_START_LONG,
                                       FAST_START_SHORT, FAST_START_LONG);
    localparam int MAX_STOP  = max_of4(STD_STOP_SHORT, STD_STOP_LONG,
                                       FAST_STOP_SHORT, FAST_STOP_LONG);
    localparam int MAX_LEN   = (MAX_START > MAX_STOP) ? MAX_START : MAX_STOP;
    localparam int CNT_W     = $clog2(MAX_LEN + 1);

    logic             start_req;
    logic             stop_req;
    logic [CNT_W-1:0] len_sel;

    cond_req_decode dec_i (
        .stat_wr   (stat_wr),
        .wr_master (wr_master),
        .wr_xmit   (wr_xmit),
        .wr_busy   (wr_busy),
        .if_en     (if_en),
        .bus_busy  (bus_busy),
        .start_req (start_req),
        .stop_req  (stop_req)
    );

    cond_time_sel #(
        .STD_START_SHORT  (STD_START_SHORT),
        .STD_START_LONG   (STD_START_LONG),
        .FAST_START_SHORT (FAST_START_SHORT),
        .FAST_START_LONG  (FAST_START_LONG),
        .STD_STOP_SHORT   (STD_STOP_SHORT),
        .STD_STOP_LONG    (STD_STOP_LONG),
        .FAST_STOP_SHORT  (FAST_STOP_SHORT),
        .FAST_STOP_LONG   (FAST_STOP_LONG),
        .CNT_W            (CNT_W)
    ) tsel_i (
        .is_stop   (stop_req),
        .fast_mode (fast_mode),
        .long_sel  (long_sel),
        .period    (len_sel)
    );

    cond_sequencer #(
        .CNT_W (CNT_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .len_in    (len_sel),
        .scl_drv   (scl_drv),
        .sda_drv   (sda_drv),
        .done      (cond_done),
        .bit_clr   (bit_clr)
    );

    // R11
    scl_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drv |-> sda_drv);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_done |=> !cond_done);

    // R8
    clr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_clr |-> cond_done);

    // R7
    sda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_drv) |-> (cond_done && !scl_drv && !bit_clr));

    // R4
    start_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drv) |-> (bit_clr && sda_drv));

endmodule

// File: tb/i2c_cond_gen_tb.sv
module i2c_cond_gen_tb_top;

    logic clk = 1'b0;
    logic rst_n;
    logic stat_wr, wr_master, wr_xmit, wr_busy;
    logic if_en, fast_mode, long_sel, bus_busy;
    logic scl_drv, sda_drv, cond_done, bit_clr;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_cond_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_wr   (stat_wr),
        .wr_master (wr_master),
        .wr_xmit   (wr_xmit),
        .wr_busy   (wr_busy),
        .if_en     (if_en),
        .fast_mode (fast_mode),
        .long_sel  (long_sel),
        .bus_busy  (bus_busy),
        .scl_drv   (scl_drv),
        .sda_drv   (sda_drv),
        .cond_done (cond_done),
        .bit_clr   (bit_clr)
    );

    // R5 / R6 timing table, written from the requirements
    function automatic int exp_len(input bit is_stop, input bit f, input bit l);
        if (!is_stop) return f ? (l ? 26 : 10) : (l ? 52 : 20);
        return f ? (l ? 28 : 12) : (l ? 54 : 22);
    endfunction

    // expected {scl, sda, done, clr} at sample i after the request edge
    function automatic logic [3:0] exp_vec(input bit is_stop, input int t, input int i);
        if (!is_stop) begin
            if (i <= t)         return 4'b0000;
            if (i <= 2 * t)     return 4'b0100;
            if (i == 2 * t + 1) return 4'b1111;
            return 4'b1100;
        end
        if (i <= t)     return 4'b0100;
        if (i == t + 1) return 4'b0010;
        return 4'b0000;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {scl,sda,done,clr} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic issue(input bit m, input bit x, input bit b);
        stat_wr   = 1'b1;
        wr_master = m;
        wr_xmit   = x;
        wr_busy   = b;
    endtask

    task automatic idle_inputs();
        stat_wr   = 1'b0;
        wr_master = 1'b0;
        wr_xmit   = 1'b0;
        wr_busy   = 1'b0;
    endtask

    // R4 R5 R6 R7 R8 R9: full sequence check, one check per cycle
    task automatic run_seq(input bit is_stop, input bit f, input bit l,
                           input bit scramble, input bit inject, input string req);
        int t;
        int total;
        t = exp_len(is_stop, f, l);
        total = is_stop ? t + 2 : 2 * t + 2;
        @(negedge clk);
        fast_mode = f;
        long_sel  = l;
        issue(1'b1, 1'b1, !is_stop);
        for (int i = 1; i <= total; i++) begin
            @(negedge clk);
            check(req, {scl_drv, sda_drv, cond_done, bit_clr}, exp_vec(is_stop, t, i));
            idle_inputs();
            if (scramble) begin
                fast_mode = 1'($urandom);
                long_sel  = 1'($urandom);
            end
            if (inject && i == 2) begin
                issue(1'($urandom), 1'($urandom), 1'($urandom));
                wr_master = 1'b1;
                wr_xmit   = 1'b1;
            end
        end
    endtask

    // R10: a write that must be ignored; outputs hold exp for n cycles
    task automatic ignored_write(input bit m, input bit x, input bit b,
                                 input logic [3:0] exp, input string req);
        @(negedge clk);
        issue(m, x, b);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            idle_inputs();
            check(req, {scl_drv, sda_drv, cond_done, bit_clr}, exp);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n     = 1'b0;
        if_en     = 1'b1;
        fast_mode = 1'b0;
        long_sel  = 1'b0;
        bus_busy  = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        check("R1 in reset", {scl_drv, sda_drv, cond_done, bit_clr}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {scl_drv, sda_drv, cond_done, bit_clr}, 4'b0000);

        // R10: START gated by bus_busy
        bus_busy = 1'b1;
        ignored_write(1'b1, 1'b1, 1'b1, 4'b0000, "R10 start while bus busy");
        bus_busy = 1'b0;
        // R10: wrong pattern does nothing
        ignored_write(1'b0, 1'b1, 1'b1, 4'b0000, "R10 master=0 write");
        ignored_write(1'b1, 1'b0, 1'b0, 4'b0000, "R10 xmit=0 write");

        // R2 R4 R5: START standard short
        run_seq(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 R4 R5 start std short");
        // R10: START while held is ignored
        ignored_write(1'b1, 1'b1, 1'b1, 4'b1100, "R10 start while held");
        // R10: STOP with if_en=0 ignored
        if_en = 1'b0;
        ignored_write(1'b1, 1'b1, 1'b0, 4'b1100, "R10 stop with if_en=0");
        if_en = 1'b1;
        // R3 R6 R7: STOP standard short from held
        run_seq(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3 R6 R7 stop std short");
        // R3: STOP from idle
        run_seq(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R3 R6 stop fast long from idle");
        // R5 R6: other table corners
        run_seq(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 start fast long");
        run_seq(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 stop std long");
        run_seq(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R5 R9 start std long inject");
        run_seq(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R6 R9 stop fast short scramble");
        run_seq(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R5 R9 start fast short scramble");
        run_seq(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6 stop fast long");

        // random mix: START then STOP with random options
        for (int k = 0; k < 16; k++) begin
            run_seq(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    "R4 R8 R9 random start");
            run_seq(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    "R7 R8 R9 random stop");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule